// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may proceed against the permission field of an already translated page. Three access attributes form a 3-bit access class: write, instruction fetch and supervisor. The class and the page's 3-bit permission value give a fault code and a read/write/execute grant mask. Both results are combinational, so the translation logic can use them in the same cycle.

The block also holds the fault status and fault address registers. They are loaded on every faulting access that is presented with `acc_valid`. If a second fault arrives before software has read the status, the overflow bit marks it. A one-cycle read strobe returns the status and clears it.

When no-fault mode is on, or traps are disabled, a fault is still recorded but raises no exception, and the access receives full rights. Otherwise a registered one-cycle pulse goes out on the instruction-fault or the data-fault line. Write permission is withheld from a page whose modified bit is clear, so that the first store to that page traps.

Top module: `mmu_perm_check`

## Requirements
- R1: `fault_code` is 12 (privilege violation) for any access with `acc_super`=0 to permission value 6 or 7. Otherwise it is 8 (protection error) when a needed right is missing, and 0 when nothing is missing. A plain read needs R, a fetch needs X, a write needs W, and a write with fetch set needs both W and X.
- R2: Rights per permission value 0..7 are, for user access: R, RW, RX, RWX, X, R, none, none. For supervisor access they are: R, RW, RX, RWX, X, RW, RX, RWX. When there is no fault, `prot_mask` shows them with bit 0 = read, bit 1 = write, bit 2 = execute.
- R3: `prot_mask` bit 1 is 0 whenever `acc_modified` is 0.
- R4: A faulting access with `acc_valid`=1 sets the status register on the next edge as follows:
  - bits 7:5 hold the access class {write, fetch, supervisor};
  - bits 3:2 hold `fault_code`[3:2];
  - bit 1 is set (address valid);
  - bit 4 is 0.
  On the same edge `fault_addr` takes `acc_addr`.
- R5: If the status register is nonzero and is not being read when a new fault arrives, its old contents are dropped and bit 0 (overflow) is set in the new value.
- R6: `fsr_read` clears the status register on the next edge. If a fault arrives in the same cycle, the new fault is loaded with overflow 0.
- R7: With `nofault_mode`=0 and `traps_on`=1, a faulting valid access gives a one-cycle pulse one edge later. The pulse goes on `ifault_pulse` when `acc_ifetch` is set, and on `dfault_pulse` when it is not.
- R8: With `nofault_mode`=1 or `traps_on`=0, a fault raises no pulse, `prot_mask` is 7, and the registers are still loaded. With neither condition, a fault gives `prot_mask` 0.
- R9: An access with `acc_valid`=0 changes neither register and raises no pulse, whatever its fault code.
- R10: After reset the status register, the address register and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access is reported this cycle |
| acc_write | input | 1 | Access is a write |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made in supervisor mode |
| acc_perm | input | 3 | Permission field of the page |
| acc_modified | input | 1 | Modified bit of the page |
| acc_addr | input | ADDR_W | Address of the access |
| nofault_mode | input | 1 | Control bit: record faults without raising them |
| traps_on | input | 1 | Traps enabled |
| fsr_read | input | 1 | Read strobe that clears the status register |
| fault_code | output | 4 | 0 ok, 8 protection, 12 privilege |
| prot_mask | output | 3 | Granted rights {X, W, R} |
| fault_status | output | FSR_W | Fault status register |
| fault_addr | output | ADDR_W | Fault address register |
| ifault_pulse | output | 1 | Instruction fault exception pulse |
| dfault_pulse | output | 1 | Data fault exception pulse |

## Verification
The bench sweeps every pairing of access class and permission value, and every modified and suppression setting. This exposes a design with a misplaced matrix entry, such as one that grants supervisor reads on an execute-only page, or one that lets user code touch permission 6 or 7 with only a protection error. Back-to-back faults with sparse reads expose a design that ORs into stale status instead of collapsing it to the overflow bit. A read in the same cycle as a fault catches a design that sets overflow for a value already consumed, or that lets the clear win over the fault. The suppressed cases catch a design that drops the fault record along with the exception, and the unclassified cases catch a pulse sent on the wrong line.

// File: rtl/mmu_perm_check.sv
module mmu_perm_check #(
  parameter int ADDR_W = 32,
  parameter int FSR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_ifetch,
  input  logic              acc_super,
  input  logic [2:0]        acc_perm,
  input  logic              acc_modified,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              nofault_mode,
  input  logic              traps_on,
  input  logic              fsr_read,
  output logic [3:0]        fault_code,
  output logic [2:0]        prot_mask,
  output logic [FSR_W-1:0]  fault_status,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              ifault_pulse,
  output logic              dfault_pulse
);
  localparam int CLS_LSB = 5;
  localparam logic [7:0] USR_RD = 8'b0010_1111;
  localparam logic [7:0] USR_WR = 8'b0000_1010;
  localparam logic [7:0] USR_EX = 8'b0001_1100;
  localparam logic [7:0] SUP_RD = 8'b1110_1111;
  localparam logic [7:0] SUP_WR = 8'b1010_1010;
  localparam logic [7:0] SUP_EX = 8'b1101_1100;

  logic [2:0] acc_cls;
  logic       g_rd, g_wr, g_ex, priv_bad, lacks, faulted, quiet;
  logic [FSR_W-1:0] fsr_next;

  assign acc_cls  = {acc_write, acc_ifetch, acc_super};
  assign g_rd     = acc_super ? SUP_RD[acc_perm] : USR_RD[acc_perm];
  assign g_wr     = acc_super ? SUP_WR[acc_perm] : USR_WR[acc_perm];
  assign g_ex     = acc_super ? SUP_EX[acc_perm] : USR_EX[acc_perm];
  assign priv_bad = !acc_super && (acc_perm[2:1] == 2'b11);
  assign lacks    = (!acc_write && !acc_ifetch && !g_rd) ||
                    (acc_ifetch && !g_ex) || (acc_write && !g_wr);
  assign fault_code = priv_bad ? 4'd12 : (lacks ? 4'd8 : 4'd0);
  assign faulted  = (fault_code != 4'd0);
  assign quiet    = nofault_mode || !traps_on;
  assign prot_mask = faulted ? (quiet ? 3'b111 : 3'b000)
                             : {g_ex, g_wr && acc_modified, g_rd};

  always_comb begin
    fsr_next = '0;
    fsr_next[0] = !fsr_read && (fault_status != '0);
    fsr_next[1] = 1'b1;
    fsr_next[3:2] = fault_code[3:2];
    fsr_next[CLS_LSB +: 3] = acc_cls;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_status <= '0;
      fault_addr   <= '0;
      ifault_pulse <= 1'b0;
      dfault_pulse <= 1'b0;
    end else begin
      ifault_pulse <= acc_valid && faulted && !quiet && acc_ifetch;
      dfault_pulse <= acc_valid && faulted && !quiet && !acc_ifetch;
      if (acc_valid && faulted) begin
        fault_status <= fsr_next;
        fault_addr   <= acc_addr;
      end else if (fsr_read) begin
        fault_status <= '0;
      end
    end
  end

  p_user_priv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_super && acc_perm[2] && acc_perm[1]) |-> fault_code == 4'd12);
  p_clean_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_modified && !(faulted && quiet)) |-> !prot_mask[1]);
  p_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && faulted) |=> (fault_status[1] && fault_addr == $past(acc_addr)));
  p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && faulted && !fsr_read && fault_status != '0) |=> fault_status[0]);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_read && !(acc_valid && faulted)) |=> fault_status == '0);
  p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifault_pulse && dfault_pulse));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && quiet) |=> (!ifault_pulse && !dfault_pulse));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !fsr_read) |=> $stable(fault_status) && $stable(fault_addr));
endmodule

// File: tb/mmu_perm_check_tb.sv
module mmu_perm_check_tb_top;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_ifetch = 0, acc_super = 0;
  logic [2:0] acc_perm = 0;
  logic acc_modified = 0, nofault_mode = 0, traps_on = 1, fsr_read = 0;
  logic [31:0] acc_addr = 0;
  logic [3:0] fault_code;
  logic [2:0] prot_mask;
  logic [7:0] fault_status;
  logic [31:0] fault_addr;
  logic ifault_pulse, dfault_pulse;
  int checks = 0, fails = 0;
  logic [7:0] fsr_m = 0;
  logic [31:0] far_m = 0;
  logic ip_m = 0, dp_m = 0;

  mmu_perm_check dut_i (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_ifetch(acc_ifetch), .acc_super(acc_super),
    .acc_perm(acc_perm), .acc_modified(acc_modified), .acc_addr(acc_addr),
    .nofault_mode(nofault_mode), .traps_on(traps_on), .fsr_read(fsr_read),
    .fault_code(fault_code), .prot_mask(prot_mask), .fault_status(fault_status),
    .fault_addr(fault_addr), .ifault_pulse(ifault_pulse), .dfault_pulse(dfault_pulse));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] rights(input logic sup, input logic [2:0] p);
    if (sup) case (p)
      0: return 3'b001; 1: return 3'b011; 2: return 3'b101; 3: return 3'b111;
      4: return 3'b100; 5: return 3'b011; 6: return 3'b101; default: return 3'b111;
    endcase
    else case (p)
      0: return 3'b001; 1: return 3'b011; 2: return 3'b101; 3: return 3'b111;
      4: return 3'b100; 5: return 3'b001; default: return 3'b000;
    endcase
  endfunction

  function automatic logic [3:0] code_of(input logic [2:0] cls, input logic [2:0] p);
    logic [2:0] g;
    if (!cls[0] && p >= 6) return 4'd12;
    g = rights(cls[0], p);
    if ((cls[2] && !g[1]) || (cls[1] && !g[2]) || (!cls[2] && !cls[1] && !g[0])) return 4'd8;
    return 4'd0;
  endfunction

  task automatic drive(input logic v, input logic [2:0] cls, input logic [2:0] p,
                       input logic m, input logic nf, input logic te, input logic rd,
                       input logic [31:0] a);
    acc_valid = v; {acc_write, acc_ifetch, acc_super} = cls; acc_perm = p;
    acc_modified = m; nofault_mode = nf; traps_on = te; fsr_read = rd; acc_addr = a;
  endtask

  task automatic model(input logic v, input logic [2:0] cls, input logic [2:0] p,
                       input logic nf, input logic te, input logic rd, input logic [31:0] a);
    logic [3:0] c;
    c = code_of(cls, p);
    ip_m = v && c != 0 && !nf && te && cls[1];
    dp_m = v && c != 0 && !nf && te && !cls[1];
    if (v && c != 0) begin
      fsr_m = {cls, 1'b0, c[3:2], 1'b1, (!rd && fsr_m != 0)};
      far_m = a;
    end else if (rd) fsr_m = 0;
  endtask

  initial begin
    #190000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 status", fault_status, 0);
    check("R10 addr", fault_addr, 0);
    check("R10 pulses", {ifault_pulse, dfault_pulse}, 0);

    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 4; s++) begin
            logic [3:0] ec;
            logic [2:0] g, ep;
            drive(0, 3'(c), 3'(p), m[0], s[0], s[1], 0, 0);
            #1;
            ec = code_of(3'(c), 3'(p));
            g = rights(c[0], 3'(p));
            if (ec != 0) ep = (s[0] || !s[1]) ? 3'b111 : 3'b000;
            else ep = {g[2], g[1] & m[0], g[0]};
            check("R1 code", fault_code, ec);
            if (ec != 0) check("R8 mask", prot_mask, ep);
            else if (!m[0]) check("R3 mask", prot_mask, ep);
            else check("R2 mask", prot_mask, ep);
          end

    drive(0, 3'b000, 3'd6, 0, 0, 1, 0, 32'hdead_0000);
    @(posedge clk); @(negedge clk);
    check("R9 status", fault_status, 0);
    check("R9 addr", fault_addr, 0);
    check("R9 pulses", {ifault_pulse, dfault_pulse}, 0);

    n = 0;
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 4; s++) begin
          logic rd, ov, flt;
          logic [31:0] a;
          rd = (n % 3 == 0);
          a = 32'h1000_0000 + 32'(n) * 32'h0001_0104;
          flt = code_of(3'(c), 3'(p)) != 0;
          ov = flt && !rd && fsr_m != 0;
          drive(1, 3'(c), 3'(p), n[0], s[0], s[1], rd, a);
          model(1, 3'(c), 3'(p), s[0], s[1], rd, a);
          @(posedge clk); @(negedge clk);
          if (ov) check("R5 status", fault_status, fsr_m);
          else if (rd) check("R6 status", fault_status, fsr_m);
          else check("R4 status", fault_status, fsr_m);
          check("R4 addr", fault_addr, far_m);
          if (s[0] || !s[1]) check("R8 pulses", {ifault_pulse, dfault_pulse}, {ip_m, dp_m});
          else check("R7 pulses", {ifault_pulse, dfault_pulse}, {ip_m, dp_m});
          n++;
        end

    drive(0, 3'b000, 3'd0, 0, 0, 1, 1, 0);
    @(posedge clk); @(negedge clk);
    check("R6 cleared", fault_status, 0);
    check("R7 pulse one cycle", {ifault_pulse, dfault_pulse}, 0);
    fsr_read = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule